// File: doc/BRIEF.md
# SPI Register Bridge with Selectable Payload Ordering

This block is an SPI target (clock idle low, MOSI sampled on the rising SCLK edge, MISO changed on the falling edge). It lets an external host read and write a 32-bit internal register bus that uses a request/acknowledge handshake with any latency. Every frame opens with a 24-bit address field sent most significant bit first. Bit 23 of that field selects the direction (1 = write, 0 = read), and bits 22:0 give the word address. A 32-bit payload follows. The byte order and bit order of the payload can each be chosen, so the host can exchange words in its native layout.

Reads need a gap between the address and the data. The target clocks out a programmable number of padding bytes, all zero, after the address. This gives a slow register behind the bus time to answer before the first data bit has to leave. If the data is still missing at that moment, a sticky error flag is set. Two local registers sit inside the block and never reach the bus. One holds the payload ordering. The other is a configuration/status word that holds the padding count, the error flag and a fixed interface code.

The SPI pins are oversampled by the system clock, so SCLK must stay well below the system clock rate (half-period of at least four system cycles). The frame controller has these states. IDLE: deselected. ADDR: shifting the address in. WDATA: shifting a write payload in. PAD: clocking padding bytes. RDATA: shifting the read word out. DONE: waiting for deselect. The transitions are:
- IDLE→ADDR when CS_n falls.
- ADDR→WDATA after the 24th bit if bit 23 was 1.
- ADDR→PAD after the 24th bit of a read with a non-zero padding count.
- ADDR→RDATA after the 24th bit of a read with zero padding.
- PAD→RDATA after 8×padding bits.
- WDATA→DONE and RDATA→DONE after 32 payload bits.
- Any state→IDLE when CS_n rises.

Top module: `spi_regbridge`

## Requirements
- R1: The address field is taken most significant bit first, whatever the ordering setting. Bit 23 = 1 marks a write, and bits 22:0 are the word address. A complete write to a non-local address gives exactly one bus write carrying that address and the decoded payload.
- R2: Ordering setting bit 0 selects the byte order: 0 sends payload bits 7:0 as the first byte and 31:24 as the last; 1 sends 31:24 first. Setting bit 1 selects the bit order inside each byte: 0 sends the highest bit first; 1 sends the lowest bit first. The same layout applies to write payloads and read data.
- R3: A write to the ordering register (word address 0x7FFF00) takes the new setting from bits 1:0 of the payload, decoded with the setting active before the write. A word whose bytes are all {s0,s1,0,0,0,0,s1,s0} therefore decodes alike under all four layouts. Reading this register returns the setting in bits 1:0 and zeros above.
- R4: On a read, MISO stays low through the 24 address bits and the padding bits. The padding is 8×P bits, where P is status bits 3:0. The first data bit is valid at the rising edge of bit 24+8P.
- R5: A read of a non-local address issues one bus read when the address completes. The word latched at acknowledge is sent out in the active ordering.
- R6: If the read word is not yet latched at the falling edge that launches the first data bit, status bit 16 is set and the frame returns all-zero data.
- R7: Status bit 16 stays set until the status register (word address 0x7FFF01) is read. That read returns the bit set and clears it, so the next status read shows it clear.
- R8: Status bits 31:24 always read 0xC5. Bits 23:17 and 15:4 read 0. A write to the status register changes only bits 3:0.
- R9: After reset the ordering setting is 0, the padding count and error flag are 0, bus_req is low and MISO is low.
- R10: A frame cut short by CS_n rising issues no bus write and changes no local register. The next frame is decoded from its first bit.
- R11: MISO and its output enable are low while CS_n is high. The enable is high while CS_n is low.
- R12: bus_req, once raised, stays high with bus_we, bus_addr and bus_wdata unchanged until bus_ack. Each completed non-local frame makes exactly one request.
- R13: Accesses to the two local addresses never raise bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for MISO pad |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 23 | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Request completed (one-cycle pulse) |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
A wrong ordering setting, or a byte or bit slot swapped in the serializer, shows up as a corrupted word on the very next read or write. It can be seen at the bus on a write, or on MISO bit by bit on a read. A bit counter that is off by one moves the first data bit into the padding window, or misplaces the direction bit. Either shows within one frame as non-zero MISO before bit 24+8P, or as a write that never appears. A lost or stuck error flag appears only on the following status read. That is why the bench reads the status word twice after a late acknowledge. Abort handling is exposed by the bus monitor, which counts any write it did not expect.

// File: rtl/srb_pkg.sv
package srb_pkg;

    localparam int WORD_W = 32;
    localparam int NBYTES = WORD_W / 8;

    typedef struct packed {
        logic lsb_first;   // bit 1: bit order inside a byte
        logic big_endian;  // bit 0: byte order of the word
    } order_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WDATA,
        S_PAD,
        S_RDATA,
        S_DONE
    } frame_state_t;

    // Word value -> serial image, image bit WORD_W-1 leaves first.
    function automatic logic [WORD_W-1:0] to_wire(input logic [WORD_W-1:0] v, input order_t o);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int k = 0; k < NBYTES; k++) begin
            for (int j = 0; j < 8; j++) begin
                int src_byte;
                int src_bit;
                src_byte = o.big_endian ? (NBYTES - 1 - k) : k;
                src_bit  = o.lsb_first ? j : (7 - j);
                w[WORD_W - 1 - (8 * k + j)] = v[8 * src_byte + src_bit];
            end
        end
        return w;
    endfunction

    // Serial image -> word value, exact inverse of to_wire.
    function automatic logic [WORD_W-1:0] from_wire(input logic [WORD_W-1:0] w, input order_t o);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int k = 0; k < NBYTES; k++) begin
            for (int j = 0; j < 8; j++) begin
                int dst_byte;
                int dst_bit;
                dst_byte = o.big_endian ? (NBYTES - 1 - k) : k;
                dst_bit  = o.lsb_first ? j : (7 - j);
                v[8 * dst_byte + dst_bit] = w[WORD_W - 1 - (8 * k + j)];
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/srb_spi_front.sv
module srb_spi_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic sel,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_bit
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b010; // cs_n idles high

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_prev;

    assign raw = {spi_mosi, spi_cs_n, spi_sclk};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {SYNC_STAGES{RST_VAL[g]}};
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= synced[0];
    end

    assign sel       = ~synced[1];
    assign mosi_bit  = synced[2];
    assign sclk_rise = sel &  synced[0] & ~sclk_prev;
    assign sclk_fall = sel & ~synced[0] &  sclk_prev;

endmodule

// File: rtl/srb_frame_fsm.sv
module srb_frame_fsm
    import srb_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int PAD_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 mosi_bit,
    input  order_t               order,
    input  logic [PAD_W-1:0]     pad,
    input  logic                 data_ok,
    input  logic [WORD_W-1:0]    rd_word,
    output logic                 op_start,
    output logic                 op_we,
    output logic [ADDR_BITS-2:0] op_addr,
    output logic [WORD_W-1:0]    op_wdata,
    output logic                 launch,
    output logic                 launch_miss,
    output logic                 miso_bit
);
    localparam int CNT_W = PAD_W + 4;
    localparam int WA    = ADDR_BITS - 1;   // word address width

    frame_state_t      state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sh_in;
    logic [WORD_W-1:0] sh_out;
    logic              first_q;
    logic [CNT_W-1:0]  pad_bits;
    logic              addr_last, word_last, pad_last, is_write;
    logic [WORD_W-1:0] launch_img;

    assign pad_bits   = {1'b0, pad, 3'b000};
    assign addr_last  = (cnt == CNT_W'(ADDR_BITS - 1));
    assign word_last  = (cnt == CNT_W'(WORD_W - 1));
    assign pad_last   = (cnt == pad_bits - 1'b1);
    assign is_write   = sh_in[ADDR_BITS-2];
    assign launch_img = data_ok ? to_wire(rd_word, order) : '0;

    // next-state logic
    always_comb begin
        state_n = state;
        if (!sel) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_n = S_ADDR;
                S_ADDR:  if (sclk_rise && addr_last)
                             state_n = is_write ? S_WDATA :
                                       ((pad == '0) ? S_RDATA : S_PAD);
                S_WDATA: if (sclk_rise && word_last) state_n = S_DONE;
                S_PAD:   if (sclk_rise && pad_last)  state_n = S_RDATA;
                S_RDATA: if (sclk_rise && word_last) state_n = S_DONE;
                S_DONE:  state_n = S_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            sh_in       <= '0;
            sh_out      <= '0;
            first_q     <= 1'b1;
            op_start    <= 1'b0;
            op_we       <= 1'b0;
            op_addr     <= '0;
            op_wdata    <= '0;
            launch      <= 1'b0;
            launch_miss <= 1'b0;
            miso_bit    <= 1'b0;
        end else begin
            op_start    <= 1'b0;
            launch      <= 1'b0;
            launch_miss <= 1'b0;

            if (state_n != state) cnt <= '0;
            else if (sclk_rise)   cnt <= cnt + 1'b1;

            if (sclk_rise && (state == S_ADDR || state == S_WDATA))
                sh_in <= {sh_in[WORD_W-2:0], mosi_bit};

            if (state == S_ADDR && sclk_rise && addr_last) begin
                op_addr <= {sh_in[WA-2:0], mosi_bit};
                op_we   <= is_write;
                if (!is_write) op_start <= 1'b1;
            end

            if (state == S_WDATA && sclk_rise && word_last) begin
                op_wdata <= from_wire({sh_in[WORD_W-2:0], mosi_bit}, order);
                op_start <= 1'b1;
            end

            if (state == S_RDATA) begin
                if (sclk_fall) begin
                    if (first_q) begin
                        sh_out      <= launch_img;
                        miso_bit    <= launch_img[WORD_W-1];
                        launch      <= 1'b1;
                        launch_miss <= ~data_ok;
                        first_q     <= 1'b0;
                    end else begin
                        sh_out   <= {sh_out[WORD_W-2:0], 1'b0};
                        miso_bit <= sh_out[WORD_W-2];
                    end
                end
            end else begin
                first_q  <= 1'b1;
                miso_bit <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/srb_cfg_regs.sv
module srb_cfg_regs
    import srb_pkg::*;
#(
    parameter int          PAD_W   = 4,
    parameter logic [7:0]  IF_CODE = 8'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_order,
    input  logic [1:0]        wr_order_val,
    input  logic              wr_stat,
    input  logic [PAD_W-1:0]  wr_pad_val,
    input  logic              err_set,
    input  logic              err_clr,
    output order_t            order,
    output logic [PAD_W-1:0]  pad,
    output logic              err,
    output logic [WORD_W-1:0] stat_word,
    output logic [WORD_W-1:0] order_word
);
    localparam int ERR_BIT = 16;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order <= '0;
            pad   <= '0;
            err   <= 1'b0;
        end else begin
            if (wr_order) order <= order_t'(wr_order_val);
            if (wr_stat)  pad   <= wr_pad_val;
            if (err_set)      err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    always_comb begin
        stat_word                   = '0;
        stat_word[WORD_W-1 -: 8]    = IF_CODE;
        stat_word[ERR_BIT]          = err;
        stat_word[PAD_W-1:0]        = pad;
        order_word                  = '0;
        order_word[1:0]             = order;
    end

endmodule

// File: rtl/srb_bus_port.sv
module srb_bus_port
    import srb_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else if (bus_req) begin
            if (bus_ack) begin
                bus_req <= 1'b0;
                if (!bus_we) begin
                    rd_valid <= 1'b1;
                    rd_data  <= bus_rdata;
                end
            end
        end else if (start) begin
            bus_req   <= 1'b1;
            bus_we    <= we;
            bus_addr  <= addr;
            bus_wdata <= wdata;
            rd_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge
    import srb_pkg::*;
#(
    parameter int          ADDR_BITS   = 24,
    parameter int          PAD_W       = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  IF_CODE     = 8'hC5,
    parameter logic [22:0] ORDER_ADDR  = 23'h7FFF00,
    parameter logic [22:0] STAT_ADDR   = 23'h7FFF01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    output logic        bus_req,
    output logic        bus_we,
    output logic [22:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata
);
    localparam int AW = ADDR_BITS - 1;

    logic              sel, sclk_rise, sclk_fall, mosi_bit;
    order_t            order;
    logic [PAD_W-1:0]  pad;
    logic              err;
    logic [WORD_W-1:0] stat_word, order_word;
    logic              op_start, op_we, launch, launch_miss, miso_bit;
    logic [AW-1:0]     op_addr;
    logic [WORD_W-1:0] op_wdata;
    logic              hit_order, hit_stat, local_hit;
    logic              rd_local_q, rd_stat_q, oe_q;
    logic              port_valid, data_ok;
    logic [WORD_W-1:0] port_data, rd_word;
    logic              stat_clr;

    srb_spi_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .sel(sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_bit(mosi_bit)
    );

    srb_frame_fsm #(.ADDR_BITS(ADDR_BITS), .PAD_W(PAD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_bit(mosi_bit),
        .order(order), .pad(pad), .data_ok(data_ok), .rd_word(rd_word),
        .op_start(op_start), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .launch(launch), .launch_miss(launch_miss), .miso_bit(miso_bit)
    );

    assign hit_order = (op_addr == ORDER_ADDR);
    assign hit_stat  = (op_addr == STAT_ADDR);
    assign local_hit = hit_order | hit_stat;
    assign stat_clr  = launch & rd_stat_q;

    srb_cfg_regs #(.PAD_W(PAD_W), .IF_CODE(IF_CODE)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_order(op_start & op_we & hit_order), .wr_order_val(op_wdata[1:0]),
        .wr_stat(op_start & op_we & hit_stat),   .wr_pad_val(op_wdata[PAD_W-1:0]),
        .err_set(launch_miss), .err_clr(stat_clr),
        .order(order), .pad(pad), .err(err),
        .stat_word(stat_word), .order_word(order_word)
    );

    srb_bus_port #(.AW(AW)) port_i (
        .clk(clk), .rst_n(rst_n),
        .start(op_start & ~local_hit), .we(op_we), .addr(op_addr), .wdata(op_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rd_valid(port_valid), .rd_data(port_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_local_q <= 1'b0;
            rd_stat_q  <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            oe_q <= sel;
            if (op_start && !op_we) begin
                rd_local_q <= local_hit;
                rd_stat_q  <= hit_stat;
            end
        end
    end

    assign data_ok     = rd_local_q | port_valid;
    assign rd_word     = rd_local_q ? (rd_stat_q ? stat_word : order_word) : port_data;
    assign spi_miso_oe = oe_q;
    assign spi_miso    = miso_bit & oe_q;

endmodule

// File: rtl/spi_regbridge_chk.sv
module spi_regbridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        spi_miso,
    input logic        spi_miso_oe,
    input logic        bus_req,
    input logic        bus_we,
    input logic [22:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        op_start,
    input logic        local_hit,
    input logic        launch_miss,
    input logic        stat_clr,
    input logic        err
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req);

    // R12
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> $stable({bus_we, bus_addr, bus_wdata}));

    // R11
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !spi_miso_oe && !spi_miso);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err && !stat_clr |=> err);

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_miss |=> err);

    // R13
    local_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && local_hit |=> !$rose(bus_req));

endmodule

bind spi_regbridge spi_regbridge_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .op_start(op_start), .local_hit(local_hit),
    .launch_miss(launch_miss), .stat_clr(stat_clr), .err(err)
);

// File: tb/spi_regbridge_tb_top.sv
module spi_regbridge_tb_top;

    localparam int          HALF   = 10;          // clk cycles per SCLK half period
    localparam logic [22:0] A_ORD  = 23'h7FFF00;
    localparam logic [22:0] A_STAT = 23'h7FFF01;
    localparam logic [31:0] ID_W   = 32'hC500_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic        bus_req, bus_we, bus_ack;
    logic [22:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int ntests = 0, nfail = 0;
    int lat = 1, nreq = 0, exp_nreq = 0, cnt = 0;
    bit busy = 0, done = 0;
    logic [1:0] cur = 2'b00;
    logic [54:0] expq[$];

    always #4 clk = ~clk;   // 125 MHz

    spi_regbridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [22:0] a);
        return {8'h5A ^ a[7:0], 8'hC3, a[15:8], 8'h3C};
    endfunction

    // serial stream index s (0 = first on the wire) lives in image bit 31-s
    function automatic logic [31:0] wire_of(input logic [31:0] v, input logic [1:0] o);
        logic [31:0] w;
        for (int s = 0; s < 32; s++) begin
            int byt, bt;
            byt = o[0] ? 3 - s / 8 : s / 8;
            bt  = o[1] ? s % 8 : 7 - s % 8;
            w[31 - s] = v[8 * byt + bt];
        end
        return w;
    endfunction

    function automatic logic [31:0] word_of(input logic [31:0] w, input logic [1:0] o);
        logic [31:0] v;
        for (int s = 0; s < 32; s++) begin
            int byt, bt;
            byt = o[0] ? 3 - s / 8 : s / 8;
            bt  = o[1] ? s % 8 : 7 - s % 8;
            v[8 * byt + bt] = w[31 - s];
        end
        return v;
    endfunction

    function automatic logic [31:0] ord_pat(input logic [1:0] s);
        logic [7:0] b;
        b = {s[0], s[1], 4'b0000, s[1], s[0]};
        return {4{b}};
    endfunction

    task automatic xfer(input logic [23:0] af, input logic [31:0] txw, input int padb,
                        input int cut, output logic [31:0] rxw);
        int n, d0;
        bit quiet;
        quiet = 1;
        rxw = '0;
        d0 = 24 + 8 * padb;
        n = af[23] ? 56 : d0 + 32;
        if (cut > 0) n = cut;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            spi_mosi = (i < 24) ? af[23 - i] : (af[23] ? txw[31 - (i - 24)] : 1'b0);
            repeat (HALF) @(negedge clk);
            if (i == 0) check("R11 oe while selected", {31'b0, spi_miso_oe}, 32'd1);
            if (!af[23] && i >= d0) rxw[31 - (i - d0)] = spi_miso;
            else if (spi_miso) quiet = 0;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        if (!af[23] && cut == 0) check("R4 miso low before data", {31'b0, quiet}, 32'd1);
    endtask

    task automatic host_write(input logic [22:0] a, input logic [31:0] v);
        logic [31:0] dummy;
        if (a != A_ORD && a != A_STAT) begin
            expq.push_back({a, v});
            exp_nreq++;
        end
        xfer({1'b1, a}, wire_of(v, cur), 0, 0, dummy);
    endtask

    task automatic host_read(input logic [22:0] a, input int padb, output logic [31:0] v);
        logic [31:0] w;
        if (a != A_ORD && a != A_STAT) exp_nreq++;
        xfer({1'b0, a}, 32'h0, padb, 0, w);
        v = word_of(w, cur);
    endtask

    task automatic set_order(input logic [1:0] s);
        host_write(A_ORD, ord_pat(s));
        cur = s;
    endtask

    // bus responder and monitor: pops expected writes, answers reads
    initial begin
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            bus_ack <= 1'b0;
            if (!rst_n) begin
                busy = 0;
            end else if (!busy && bus_req && !bus_ack) begin
                busy = 1;
                cnt = lat;
                nreq++;
            end else if (busy) begin
                if (cnt > 0) cnt--;
                else begin
                    busy = 0;
                    bus_ack <= 1'b1;
                    if (bus_we) begin
                        if (expq.size() == 0) begin
                            ntests++; nfail++;
                            $display("FAIL R10/R13 unexpected write actual=%h:%h expected=none",
                                     bus_addr, bus_wdata);
                        end else begin
                            logic [54:0] e;
                            e = expq.pop_front();
                            check("R1 write addr", {9'b0, bus_addr}, {9'b0, e[54:32]});
                            check("R2 write data", bus_wdata, e[31:0]);
                        end
                    end else begin
                        bus_rdata <= pat(bus_addr);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            ntests++; nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        check("R9 miso after reset", {30'b0, spi_miso_oe, spi_miso}, 32'd0);
        check("R9 bus_req after reset", {31'b0, bus_req}, 32'd0);
        host_read(A_STAT, 0, r);
        check("R8 R9 status after reset", r, ID_W);
        host_read(A_ORD, 0, r);
        check("R9 order after reset", r, 32'd0);

        // default layout
        host_write(23'h000123, 32'h11223344);
        host_read(23'h000456, 0, r);
        check("R5 read default layout", r, pat(23'h000456));

        // the three other layouts
        for (int o = 1; o < 4; o++) begin
            set_order(2'(o));
            host_read(A_ORD, 0, r);
            check("R3 order readback", r, 32'(o));
            host_write(23'h000200 + 23'(o), 32'hA1B2C3D4 ^ 32'(o));
            host_read(23'h000300 + 23'(o), 0, r);
            check("R2 read in layout", r, pat(23'h000300 + 23'(o)));
        end

        // padding hides a slow register
        set_order(2'b00);
        host_write(A_STAT, 32'hFFFF_FFF2);
        lat = 100;
        host_read(23'h000777, 2, r);
        check("R4 padded read data", r, pat(23'h000777));
        lat = 1;
        host_read(A_STAT, 2, r);
        check("R8 status pad field", r, ID_W | 32'd2);

        // too-fast access
        host_write(A_STAT, 32'h0);
        lat = 60;
        host_read(23'h000888, 0, r);
        check("R6 late data returns zero", r, 32'd0);
        lat = 1;
        host_read(A_STAT, 0, r);
        check("R7 error flag set", r, ID_W | 32'h0001_0000);
        host_read(A_STAT, 0, r);
        check("R7 error flag cleared by read", r, ID_W);

        // aborted frames
        begin
            logic [31:0] dummy;
            xfer({1'b1, 23'h000999}, wire_of(32'hDEADBEEF, cur), 0, 40, dummy);
            xfer({1'b1, A_STAT}, wire_of(32'h5, cur), 0, 50, dummy);
        end
        host_read(A_STAT, 0, r);
        check("R10 aborted status write ignored", r, ID_W);
        host_write(23'h000AAA, 32'h0BAD_F00D);
        host_read(23'h000AAB, 0, r);
        check("R10 frame after abort", r, pat(23'h000AAB));

        repeat (20) @(negedge clk);
        check("R11 miso idle", {30'b0, spi_miso_oe, spi_miso}, 32'd0);
        check("R12 R13 request count", 32'(nreq), 32'(exp_nreq));
        check("R1 all writes seen", 32'(expq.size()), 32'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule